// File: doc/BRIEF.md
# Addressed Sorting Register Bank

This block puts a fixed-size pipelined sorting network behind a small addressed register bus. A host loads the words to be ordered one per write into data slots 0 to P-1, then writes to address P to launch a sort. The block hands the whole stored vector to the network in one cycle. When the network's result emerges, the block writes it back into the same slots in a single cycle, so the host reads the ascending result from the addresses it loaded.

Loading and reading back are serial, one word per bus access, while the ordering itself runs fully in parallel. Address P also serves as a status word. It shows whether a sort is in flight and whether the last one has finished. Data writes and repeated start commands are refused while a sort is in flight. Addresses above P are unmapped.

Top module: `sortbank_top`

## Requirements
- R1: A write with `wr_en` high to address A < P stores `wdata` in slot A. A read with `rd_en` high presents that slot's value on `rdata` after the next rising edge (one cycle of latency).
- R2: A write to address P while idle starts a sort. `busy` is high from the edge after that write for exactly NS+1 cycles, where NS = log2(P)*(log2(P)+1)/2 is the number of network stages.
- R3: When `busy` falls, slots 0..P-1 hold the previously loaded words in ascending unsigned order. The result replaces the inputs in place.
- R4: A read of address P returns bit 0 = busy and bit 1 = done, with all other bits zero. `done` is set by the write-back of a finished sort, is cleared by the next start, and is never high together with `busy`.
- R5: Data-slot writes received while `busy` is high are ignored. A read of a data slot during that time returns the slot's current (pre-sort) contents.
- R6: A write to address P while `busy` is high is ignored and does not lengthen the busy period.
- R7: Reads of addresses above P return zero, and writes to them change no slot.
- R8: After reset, every slot, `rdata`, `busy` and `done` are zero.
- R9: Repeated values, all-zero and all-ones words are ordered correctly, including every mix of minimum and maximum values across the P slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | AW = log2(P)+1 | Word address for read or write |
| wdata | input | W | Write data |
| wr_en | input | 1 | Write strobe for the current address |
| rd_en | input | 1 | Read strobe; `rdata` updates after the next edge |
| rdata | output | W | Registered read data |
| busy | output | 1 | A sort is in flight |
| done | output | 1 | The last sort has been written back |

## Verification
The assertions check several rules on every cycle: `busy` and `done` are never both high, an idle start raises `busy`, a busy run never exceeds NS+1 cycles, a falling `busy` leaves `done` set, and status reads and reads of unmapped addresses return the right value. Only the bench scenarios can show that the slots end up as an ordered permutation of what was loaded. The same holds for refused writes during a sort leaving the slots untouched and for unmapped writes not aliasing onto data slots. The bench shows these through a sweep over all 256 mixes of minimum and maximum words, plus pseudo-random vectors.

// File: rtl/sortbank_pkg.sv
package sortbank_pkg;

    // Controller phases: idle, one cycle presenting the vector, waiting for result
    typedef enum logic [1:0] {
        CS_IDLE = 2'd0,
        CS_FEED = 2'd1,
        CS_WAIT = 2'd2
    } ctrl_state_e;

    function automatic int unsigned stage_count(input int unsigned lg);
        return (lg * (lg + 1)) / 2;
    endfunction

endpackage

// File: rtl/sortbank_stage.sv
// One registered layer of compare-exchange elements.
module sortbank_stage #(
    parameter int P    = 8,
    parameter int W    = 16,
    parameter int DIST = 1,
    parameter int BLK  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [P-1:0][W-1:0] din,
    output logic [P-1:0][W-1:0] dout
);

    logic [P-1:0][W-1:0] lane_d, lane_q;

    always_comb begin
        lane_d = din;
        for (int i = 0; i < P; i++) begin
            if ((i & DIST) == 0) begin
                logic [W-1:0] lo_in, hi_in;
                logic         swap;
                lo_in = din[i];
                hi_in = din[i + DIST];
                // rising order inside even blocks, falling inside odd ones
                swap  = ((i & BLK) == 0) ? (lo_in > hi_in) : (lo_in < hi_in);
                lane_d[i]        = swap ? hi_in : lo_in;
                lane_d[i + DIST] = swap ? lo_in : hi_in;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lane_q <= '0;
        else        lane_q <= lane_d;
    end

    assign dout = lane_q;

endmodule

// File: rtl/sortbank_net.sv
// Fully pipelined bitonic network with a valid marker travelling beside the data.
module sortbank_net #(
    parameter int P = 8,
    parameter int W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [P-1:0][W-1:0] in_vec,
    output logic                out_valid,
    output logic [P-1:0][W-1:0] out_vec
);

    import sortbank_pkg::*;

    localparam int LG = $clog2(P);
    localparam int NS = stage_count(LG);

    logic [P-1:0][W-1:0] lvl [0:NS];
    logic [NS-1:0]       vld_d, vld_q;

    assign lvl[0] = in_vec;

    for (genvar k = 1; k <= LG; k++) begin : g_merge
        for (genvar m = 0; m < k; m++) begin : g_step
            localparam int S = (k * (k - 1)) / 2 + m;
            localparam int J = k - 1 - m;
            sortbank_stage #(
                .P   (P),
                .W   (W),
                .DIST(1 << J),
                .BLK (1 << k)
            ) u_stage (
                .clk  (clk),
                .rst_n(rst_n),
                .din  (lvl[S]),
                .dout (lvl[S+1])
            );
        end
    end

    always_comb begin
        vld_d = {vld_q[NS-2:0], in_valid};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) vld_q <= '0;
        else        vld_q <= vld_d;
    end

    assign out_valid = vld_q[NS-1];
    assign out_vec   = lvl[NS];

endmodule

// File: rtl/sortbank_slots.sv
// Word storage with host port, bulk commit port and registered read mux.
module sortbank_slots #(
    parameter  int P  = 8,
    parameter  int W  = 16,
    localparam int AW = $clog2(P) + 1,
    localparam int IW = $clog2(P)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_wr,
    input  logic [IW-1:0]       host_idx,
    input  logic [W-1:0]        host_data,
    input  logic                commit,
    input  logic [P-1:0][W-1:0] commit_vec,
    input  logic                rd_en,
    input  logic [AW-1:0]       rd_addr,
    input  logic                stat_busy,
    input  logic                stat_done,
    output logic [P-1:0][W-1:0] words,
    output logic [W-1:0]        rdata
);

    localparam logic [AW-1:0] STAT_ADDR = AW'(P);

    typedef struct packed {
        logic [P-1:0][W-1:0] words;
        logic [W-1:0]        rdata;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (commit) begin
            bank_d.words = commit_vec;
        end else if (host_wr) begin
            bank_d.words[host_idx] = host_data;
        end
        if (rd_en) begin
            if (rd_addr < STAT_ADDR) begin
                bank_d.rdata = bank_q.words[rd_addr[IW-1:0]];
            end else if (rd_addr == STAT_ADDR) begin
                bank_d.rdata = {{(W-2){1'b0}}, stat_done, stat_busy};
            end else begin
                bank_d.rdata = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign words = bank_q.words;
    assign rdata = bank_q.rdata;

endmodule

// File: rtl/sortbank_top.sv
module sortbank_top #(
    parameter  int P  = 8,
    parameter  int W  = 16,
    localparam int AW = $clog2(P) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    input  logic          wr_en,
    input  logic          rd_en,
    output logic [W-1:0]  rdata,
    output logic          busy,
    output logic          done
);

    import sortbank_pkg::*;

    localparam int            IW        = $clog2(P);
    localparam logic [AW-1:0] START_ADDR = AW'(P);

    typedef struct packed {
        ctrl_state_e state;
        logic        done;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    logic                idle;
    logic                host_wr;
    logic                start;
    logic                commit;
    logic                net_in_valid;
    logic                net_out_valid;
    logic [P-1:0][W-1:0] slot_words;
    logic [P-1:0][W-1:0] net_result;

    always_comb begin
        idle    = (ctrl_q.state == CS_IDLE);
        host_wr = wr_en && idle && (addr < START_ADDR);
        start   = wr_en && idle && (addr == START_ADDR);
        commit  = (ctrl_q.state == CS_WAIT) && net_out_valid;

        ctrl_d = ctrl_q;
        unique case (ctrl_q.state)
            CS_IDLE: begin
                if (start) begin
                    ctrl_d.state = CS_FEED;
                    ctrl_d.done  = 1'b0;
                end
            end
            CS_FEED: begin
                ctrl_d.state = CS_WAIT;
            end
            CS_WAIT: begin
                if (net_out_valid) begin
                    ctrl_d.state = CS_IDLE;
                    ctrl_d.done  = 1'b1;
                end
            end
            default: begin
                ctrl_d.state = CS_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '{state: CS_IDLE, done: 1'b0};
        else        ctrl_q <= ctrl_d;
    end

    assign net_in_valid = (ctrl_q.state == CS_FEED);
    assign busy         = !idle;
    assign done         = ctrl_q.done;

    sortbank_net #(
        .P(P),
        .W(W)
    ) u_net (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (net_in_valid),
        .in_vec   (slot_words),
        .out_valid(net_out_valid),
        .out_vec  (net_result)
    );

    sortbank_slots #(
        .P(P),
        .W(W)
    ) u_slots (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_wr   (host_wr),
        .host_idx  (addr[IW-1:0]),
        .host_data (wdata),
        .commit    (commit),
        .commit_vec(net_result),
        .rd_en     (rd_en),
        .rd_addr   (addr),
        .stat_busy (busy),
        .stat_done (ctrl_q.done),
        .words     (slot_words),
        .rdata     (rdata)
    );

endmodule

// File: rtl/sortbank_chk.sv
module sortbank_chk #(
    parameter  int P  = 8,
    parameter  int W  = 16,
    localparam int AW = $clog2(P) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] addr,
    input logic          wr_en,
    input logic          rd_en,
    input logic [W-1:0]  rdata,
    input logic          busy,
    input logic          done
);

    localparam int            LG    = $clog2(P);
    localparam int            NS    = (LG * (LG + 1)) / 2;
    localparam logic [AW-1:0] START = AW'(P);

    // consecutive busy cycles seen before the current one
    logic [7:0] run_q;
    always_ff @(posedge clk) begin
        if (!rst_n)    run_q <= '0;
        else if (busy) run_q <= run_q + 8'd1;
        else           run_q <= '0;
    end

    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done)); // R4

    AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wr_en && addr == START) |=> busy); // R2

    AST_BUSY_RUN_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_q <= 8'(NS))); // R2

    AST_DONE_ON_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R4

    AST_STATUS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == START) |=> (rdata == {{(W-2){1'b0}}, $past(done), $past(busy)})); // R4

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr > START) |=> (rdata == '0)); // R7

endmodule

bind sortbank_top sortbank_chk #(.P(P), .W(W)) u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .addr (addr),
    .wr_en(wr_en),
    .rd_en(rd_en),
    .rdata(rdata),
    .busy (busy),
    .done (done)
);

// File: tb/test_sortbank_top.sv
module test_sortbank_top;

    localparam int P  = 8;
    localparam int W  = 16;
    localparam int AW = $clog2(P) + 1;
    localparam int NS = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [W-1:0]  wdata = '0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [W-1:0]  rdata;
    logic          busy;
    logic          done;

    int checks = 0;
    int fails  = 0;

    logic [W-1:0] vec [P];
    logic [W-1:0] exp_v [P];

    always #4 clk = ~clk;

    sortbank_top #(.P(P), .W(W)) i_sortbank_top (
        .clk  (clk),
        .rst_n(rst_n),
        .addr (addr),
        .wdata(wdata),
        .wr_en(wr_en),
        .rd_en(rd_en),
        .rdata(rdata),
        .busy (busy),
        .done (done)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // Both tasks start and end at a falling edge, one bus cycle each.
    task automatic bus_write(input int a, input logic [W-1:0] d);
        addr  = AW'(a);
        wdata = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input int a, output logic [W-1:0] d);
        addr  = AW'(a);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic make_expected();
        for (int i = 0; i < P; i++) exp_v[i] = vec[i];
        for (int i = 0; i < P; i++)
            for (int j = 0; j < P - 1 - i; j++)
                if (exp_v[j] > exp_v[j+1]) begin
                    logic [W-1:0] t;
                    t = exp_v[j]; exp_v[j] = exp_v[j+1]; exp_v[j+1] = t;
                end
    endtask

    // load, start, time the busy period, read back and compare
    task automatic run_sort(input string req);
        int cnt;
        logic [W-1:0] r;
        bit ok;
        int bad_act, bad_exp;
        make_expected();
        for (int i = 0; i < P; i++) bus_write(i, vec[i]);
        bus_write(P, '0);
        cnt = 0;
        while (busy) begin
            cnt++;
            @(negedge clk);
        end
        check(cnt == NS + 1, "R2 busy length", cnt, NS + 1);
        ok = 1; bad_act = 0; bad_exp = 0;
        for (int i = 0; i < P; i++) begin
            bus_read(i, r);
            if (r !== exp_v[i] && ok) begin
                ok = 0; bad_act = int'(r); bad_exp = int'(exp_v[i]);
            end
        end
        check(ok, req, bad_act, bad_exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [W-1:0] r;
        int cnt;
        int unsigned seed;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R8 reset state
        check(busy == 1'b0 && done == 1'b0, "R8 busy/done", {busy, done}, 0);
        check(rdata == '0, "R8 rdata", int'(rdata), 0);
        for (int i = 0; i < P; i++) begin
            bus_read(i, r);
            check(r == '0, "R8 slot", int'(r), 0);
        end
        bus_read(P, r);
        check(r == '0, "R8 status", int'(r), 0);

        // R1 plain write/readback with one-cycle latency
        for (int i = 0; i < P; i++) bus_write(i, W'(1000 + 37 * i));
        for (int i = 0; i < P; i++) begin
            bus_read(i, r);
            check(r == W'(1000 + 37 * i), "R1 readback", int'(r), 1000 + 37 * i);
        end

        // R3 worked example extended to eight words
        vec[0] = 2376; vec[1] = 7843; vec[2] = 2230; vec[3] = 129;
        vec[4] = 5000; vec[5] = 17;   vec[6] = 9999; vec[7] = 2230;
        run_sort("R3 example order");
        check(done == 1'b1 && busy == 1'b0, "R4 done port", {busy, done}, 1);
        bus_read(P, r);
        check(r == 16'd2, "R4 status after finish", int'(r), 2);

        // R9 every mix of zero and all-ones words
        for (int v = 0; v < 256; v++) begin
            for (int i = 0; i < P; i++) vec[i] = v[i] ? '1 : '0;
            run_sort("R9 min/max mix");
        end

        // R3 pseudo-random vectors, with forced duplicates (R9)
        seed = 32'h1234_5678;
        for (int n = 0; n < 40; n++) begin
            for (int i = 0; i < P; i++) begin
                seed = seed * 32'd1664525 + 32'd1013904223;
                vec[i] = seed[31:16];
            end
            if (n % 4 == 0) vec[3] = vec[6];
            run_sort("R3 random order");
        end

        // R5/R6: writes and a second start during a sort
        vec[0] = 40; vec[1] = 10; vec[2] = 70; vec[3] = 20;
        vec[4] = 60; vec[5] = 30; vec[6] = 80; vec[7] = 50;
        make_expected();
        for (int i = 0; i < P; i++) bus_write(i, vec[i]);
        bus_write(P, '0);
        cnt = 0;
        cnt += int'(busy);
        bus_write(0, 16'hDEAD);
        cnt += int'(busy);
        bus_read(0, r);
        check(r == 16'd40, "R5 slot read during sort", int'(r), 40);
        cnt += int'(busy);
        bus_read(P, r);
        check(r == 16'd1, "R4 status while busy", int'(r), 1);
        cnt += int'(busy);
        bus_write(P, '0);
        cnt += int'(busy);
        while (busy) begin
            @(negedge clk);
            cnt += int'(busy);
        end
        check(cnt == NS + 1, "R6 busy not extended", cnt, NS + 1);
        for (int i = 0; i < P; i++) begin
            bus_read(i, r);
            check(r == exp_v[i], "R5 result after ignored write", int'(r), int'(exp_v[i]));
        end

        // R7 unmapped addresses
        for (int a = P + 1; a < (1 << AW); a++) bus_write(a, W'(16'hA5A5 + a));
        for (int a = P + 1; a < (1 << AW); a++) begin
            bus_read(a, r);
            check(r == '0, "R7 unmapped read", int'(r), 0);
        end
        for (int i = 0; i < P; i++) begin
            bus_read(i, r);
            check(r == exp_v[i], "R7 slot untouched", int'(r), int'(exp_v[i]));
        end
        check(busy == 1'b0, "R7 no start from unmapped", int'(busy), 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule